// File: doc/BRIEF.md
# Management Data Line Idle Monitor

This block watches the data line of a serial PHY management bus and reports whether a PHY appears to be attached. An attached PHY normally holds the line high when nothing is driving it. A missing PHY leaves the line low. The monitor first passes the line through a synchronizer. While the management engine is idle, a detect bit copies the synchronized level on every clock. While the engine is busy, the detect bit holds its value. Tracking resumes on the first idle cycle after the transaction.

Each change of the detect bit sets a sticky change flag. The flag stays set until software clears it by writing a one, and it drives an interrupt line unless a mask bit blocks it. After a hard reset, the first valid idle sample loads the detect bit. That first load does not count as a change. The bus is a management sideband with no data stream, so every pin is a plain level or strobe and there is no valid/ready handshake or back-pressure.

The register port has a write strobe, an address and write data. Read data is combinational from the address.

Top module: `mdio_idle_mon`

## Requirements
- R1: While reset is asserted and right after it is released, `phy_det_o` is 0, `det_chg_o` is 0, `irq_o` is 0, and the mask bit (address 1, bit 0) reads 1.
- R2: After reset, the detect bit loads from the first synchronized sample taken on an idle cycle once the synchronizer is filled. With 2 stages that is the third rising edge after reset release, or later if busy. This first load never sets the change flag.
- R3: While `mgmt_busy_i` is low, a level applied to `mdio_i` appears on `phy_det_o` after SYNC_STAGES+1 rising edges (3 with default parameters). A low line gives 0 and a high line gives 1.
- R4: On every rising edge where `mgmt_busy_i` is high, `phy_det_o` keeps its value, whatever `mdio_i` does. Tracking resumes on the first edge where busy is low.
- R5: Every transition of `phy_det_o`, from 0 to 1 or from 1 to 0, sets `det_chg_o`. This includes a transition that happens when tracking resumes after a transaction.
- R6: `det_chg_o` stays set until a write to address 0 with bit 1 set. A write with bit 1 clear leaves it unchanged. If a new change and a clear fall on the same edge, the flag ends up set.
- R7: `irq_o` equals the change flag AND NOT the mask bit. The mask bit is written through address 1, bit 0.
- R8: Address 0 reads {detect in bit 0, change flag in bit 1}. Address 1 reads the mask in bit 0. All other bits and addresses read 0. Writes to addresses other than 0 and 1 change nothing.
- R9: A pulse on `mdio_i` that starts and ends while busy is high, with the synchronizer settled before busy falls, changes neither the detect bit nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset, asynchronous |
| mdio_i | input | 1 | Raw management data line level |
| mgmt_busy_i | input | 1 | High while a management transaction is in progress (clock-synchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` |
| phy_det_o | output | 1 | Detect bit (idle level of the line) |
| det_chg_o | output | 1 | Sticky change flag |
| irq_o | output | 1 | Interrupt: flag and not masked |

## Verification
The bench targets the following corner cases:

- **Power-up load:** the line is high at reset, both with busy held through the synchronizer fill and without it. A design that counted the first load as a change would raise the interrupt at power-up.
- **Busy freeze:** the line toggles while busy is held. A design that ignored busy would track those toggles and flag them, and a pulse that begins and ends inside a transaction would leak into the flag.
- **Set versus clear:** a clear write lands on the same edge as a new change. A design that gives the clear priority would lose that change.
- **Register decode:** writes go to unmapped addresses, and bit-1-clear writes go to the status address. A decoder that is too loose would corrupt the mask or the flag.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  // register addresses
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_CTRL   = 1;

  // bit positions inside the registers
  localparam int unsigned ST_DET_BIT    = 0;
  localparam int unsigned ST_CHG_BIT    = 1;
  localparam int unsigned CTRL_MASK_BIT = 0;

  // detect tracker phases
  typedef enum logic [0:0] {
    TRK_PRIME = 1'b0,
    TRK_LIVE  = 1'b1
  } trk_state_e;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("mdm_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mdm_idle_track.sv
module mdm_idle_track
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic busy_i,
  output logic det_o,
  output logic chg_o,
  output logic live_o
);

  localparam int unsigned CNT_W = $clog2(SYNC_STAGES + 1);
  localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(SYNC_STAGES);

  trk_state_e       st_q;
  logic [CNT_W-1:0] fill_q;
  logic             det_q;

  // a change is only counted once the first value has been loaded
  always_comb chg_o = (st_q == TRK_LIVE) && !busy_i && (sync_i != det_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TRK_PRIME;
      fill_q <= '0;
      det_q  <= 1'b0;
    end else begin
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
      case (st_q)
        TRK_PRIME: begin
          if ((fill_q == FILL_MAX) && !busy_i) begin
            det_q <= sync_i;
            st_q  <= TRK_LIVE;
          end
        end
        default: begin
          if (!busy_i) det_q <= sync_i;
        end
      endcase
    end
  end

  assign det_o  = det_q;
  assign live_o = (st_q == TRK_LIVE);

  // R4: busy freezes the detect bit
  a_r4_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(det_q));

  // R3: idle cycles copy the synchronized line
  a_r3_tracks_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (live_o && !busy_i) |=> (det_q == $past(sync_i)));

  // R5: a reported change always comes with a real flip of the bit
  a_r5_change_flips: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |=> (det_q != $past(det_q)));

endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_i,
  input  logic              chg_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              flag_o,
  output logic              mask_o,
  output logic              irq_o
);

  logic flag_q;
  logic mask_q;
  logic hit_status;
  logic hit_ctrl;
  logic clr_req;
  wire  unused_wdata = ^wdata_i;

  assign hit_status = (addr_i == ADDR_W'(ADDR_STATUS));
  assign hit_ctrl   = (addr_i == ADDR_W'(ADDR_CTRL));
  assign clr_req    = wr_en_i && hit_status && wdata_i[ST_CHG_BIT];

  // a new change wins over a clear on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (chg_i)   flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   mask_q <= 1'b1;
    else if (wr_en_i && hit_ctrl) mask_q <= wdata_i[CTRL_MASK_BIT];
  end

  always_comb begin
    rdata_o = '0;
    if (hit_status) begin
      rdata_o[ST_DET_BIT] = det_i;
      rdata_o[ST_CHG_BIT] = flag_q;
    end else if (hit_ctrl) begin
      rdata_o[CTRL_MASK_BIT] = mask_q;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = flag_q && !mask_q;

  // R6: the flag survives every edge that carries no clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);

  // R6: a change sets the flag even with a clear on the same edge
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i |=> flag_q);

  // R8: the mask moves only on a write to the control address
  a_r8_mask_only_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && hit_ctrl) |=> $stable(mask_q));

endmodule

// File: rtl/mdio_idle_mon.sv
module mdio_idle_mon #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdio_i,
  input  logic              mgmt_busy_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              phy_det_o,
  output logic              det_chg_o,
  output logic              irq_o
);

  logic line_sync;
  logic det_w;
  logic chg_w;
  logic live_w;
  logic mask_w;

  mdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (mdio_i),
    .q_o   (line_sync)
  );

  mdm_idle_track #(.SYNC_STAGES(SYNC_STAGES)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (line_sync),
    .busy_i (mgmt_busy_i),
    .det_o  (det_w),
    .chg_o  (chg_w),
    .live_o (live_w)
  );

  mdm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .det_i   (det_w),
    .chg_i   (chg_w),
    .wr_en_i (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .flag_o  (det_chg_o),
    .mask_o  (mask_w),
    .irq_o   (irq_o)
  );

  assign phy_det_o = det_w;

  // R2: no change can be flagged before the first value is loaded
  a_r2_quiet_until_live: assert property (@(posedge clk) disable iff (!rst_n)
    !live_w |-> !det_chg_o);

  // R7: a masked block never interrupts
  a_r7_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    mask_w |-> !irq_o);

endmodule

// File: tb/sim_mdio_idle_mon.sv
module sim_mdio_idle_mon;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mdio = 1'b0;
  logic       busy = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       det, chg, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench reference state
  bit m_s1, m_s2, m_live, m_det, m_flag, m_mask;
  int m_fill;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_idle_mon u0 (
    .clk(clk), .rst_n(rst_n), .mdio_i(mdio), .mgmt_busy_i(busy),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .phy_det_o(det), .det_chg_o(chg), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input logic [1:0] a);
    if (a == 2'd0) return {m_flag, m_det};
    if (a == 2'd1) return int'(m_mask);
    return 0;
  endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_live = 0; m_det = 0; m_flag = 0; m_mask = 1; m_fill = 0;
  endtask

  // one rising edge of the reference, using the values now driven
  task automatic model_edge();
    bit c, nd, nl, nf, nm;
    c  = m_live && !busy && (m_s2 != m_det);
    nd = m_det; nl = m_live;
    if (!m_live) begin
      if (m_fill == SYNC && !busy) begin nd = m_s2; nl = 1; end
    end else if (!busy) nd = m_s2;
    nf = c ? 1'b1 : ((wr && addr == 2'd0 && wdata[1]) ? 1'b0 : m_flag);
    nm = (wr && addr == 2'd1) ? wdata[0] : m_mask;
    if (m_fill < SYNC) m_fill++;
    m_s2 = m_s1; m_s1 = mdio;
    m_det = nd; m_live = nl; m_flag = nf; m_mask = nm;
  endtask

  task automatic compare_all();
    chk("R3", "detect", int'(det), int'(m_det));
    chk("R5", "change flag", int'(chg), int'(m_flag));
    chk("R7", "irq", int'(irq), int'(m_flag && !m_mask));
    chk("R8", "read data", int'(rdata), exp_rd(addr));
  endtask

  // called at a falling edge: drive, clock once, compare at next falling edge
  task automatic step(input bit p, input bit b, input bit w, input logic [1:0] a, input logic [7:0] d);
    mdio = p; busy = b; wr = w; addr = a; wdata = d;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input bit p, input int n, input logic [1:0] a = 2'd0);
    for (int i = 0; i < n; i++) step(p, 1'b0, 1'b0, a, 8'd0);
  endtask

  task automatic do_reset(input bit p, input bit b);
    @(negedge clk);
    rst_n = 0; mdio = p; busy = b; wr = 0; addr = 2'd0; wdata = 0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    chk("R1", "detect in reset", int'(det), 0);
    chk("R1", "flag in reset", int'(chg), 0);
    chk("R1", "irq in reset", int'(irq), 0);
    addr = 2'd1;
    #1 chk("R1", "mask in reset", int'(rdata), 1);
    addr = 2'd0;
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));

    // R1, R2: line high from reset, first load is quiet
    do_reset(1'b1, 1'b0);
    idle(1'b1, 2);
    chk("R2", "detect before fill", int'(det), 0);
    idle(1'b1, 1);
    chk("R2", "detect after first idle load", int'(det), 1);
    chk("R2", "no flag on first load", int'(chg), 0);

    // R7: unmask, nothing pending
    step(1'b1, 1'b0, 1'b1, 2'd1, 8'h00);
    chk("R7", "irq with no flag", int'(irq), 0);

    // R3, R5: line falls, appears after three edges and flags
    idle(1'b0, 2);
    chk("R3", "detect still high after two edges", int'(det), 1);
    idle(1'b0, 1);
    chk("R3", "detect low after three edges", int'(det), 0);
    chk("R5", "flag on fall", int'(chg), 1);
    chk("R7", "irq unmasked", int'(irq), 1);

    // R6: write with bit 1 clear keeps the flag, bit 1 set clears it
    step(1'b0, 1'b0, 1'b1, 2'd0, 8'hFD);
    chk("R6", "flag after zero write", int'(chg), 1);
    step(1'b0, 1'b0, 1'b1, 2'd0, 8'h02);
    chk("R6", "flag after clear", int'(chg), 0);

    // R4, R5: toggling during busy, then resume with a rise
    for (int i = 0; i < 6; i++) step(i[0], 1'b1, 1'b0, 2'd0, 8'd0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 2'd0, 8'd0);
    chk("R4", "detect frozen while busy", int'(det), 0);
    chk("R4", "no flag while busy", int'(chg), 0);
    idle(1'b1, 1);
    chk("R5", "rise on resume", int'(det), 1);
    chk("R5", "flag on resume", int'(chg), 1);
    step(1'b1, 1'b0, 1'b1, 2'd0, 8'h02);

    // R9: pulse inside a transaction
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 2'd0, 8'd0);
    idle(1'b1, 3);
    chk("R9", "hidden pulse leaves detect", int'(det), 1);
    chk("R9", "hidden pulse leaves flag", int'(chg), 0);

    // R6: clear on the same edge as a new change, set wins
    step(1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
    step(1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
    step(1'b0, 1'b0, 1'b1, 2'd0, 8'h02);
    chk("R6", "set beats clear", int'(chg), 1);

    // R8: unmapped addresses
    step(1'b0, 1'b0, 1'b1, 2'd2, 8'hFF);
    step(1'b0, 1'b0, 1'b1, 2'd3, 8'hFF);
    chk("R8", "unmapped read", int'(rdata), 0);
    step(1'b0, 1'b0, 1'b0, 2'd1, 8'd0);
    chk("R8", "mask untouched by unmapped write", int'(rdata), 0);

    // R2: busy across the synchronizer fill
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 2'd0, 8'd0);
    chk("R2", "no load while busy", int'(det), 0);
    idle(1'b1, 1);
    chk("R2", "load after busy", int'(det), 1);
    chk("R2", "quiet first load", int'(chg), 0);

    // random mix
    begin
      bit p, b;
      int burst;
      p = 1; b = 0; burst = 0;
      for (int i = 0; i < 4000; i++) begin
        bit w;
        logic [1:0] a;
        logic [7:0] d;
        if ($urandom_range(7) == 0) p = ~p;
        if (burst == 0) begin
          b = ($urandom_range(3) == 0);
          burst = $urandom_range(12, 1);
        end else burst--;
        w = ($urandom_range(9) == 0);
        a = 2'($urandom_range(3));
        d = 8'($urandom_range(255));
        step(p, b, w, a, d);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule